// File: doc/BRIEF.md
# Time-ordered enclosure event recorder

This block turns short event pulses from several enclosure sources into fixed-format log records. Typical sources are bay hot-plug controllers, the thermal policy engine and rail monitors. Each source raises a one-cycle strobe together with an event kind, a severity and the location it refers to. The recorder stamps the event with a free-running cycle counter. It also stamps it with the wall-clock value presented at that moment, the current incident number, and a bundle of telemetry inputs sampled in that same cycle. It then writes one record per event into an internal FIFO, and downstream logic drains that FIFO through a valid/ready port.

Records leave the block in strict order of the cycle counter. Events strobed in the same cycle share one stamp. They are written one after another, lowest source index first, and each carries a sequence number inside its batch. The wall-clock value is only carried along; it never affects ordering.

An event can be lost in two ways: the FIFO has no room when its turn comes, or the previous batch is still being written. Either way the event is counted, and the next record that does get written is marked.

Top module: `evtrec_builder`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rec_valid` is 0 and `drop_count` is 0. The stamp counter reads 0 in the first cycle after reset is released and increases by one every clock after that.
- R2: Record layout in `rec_data`, from the MSB down: overflow flag (1 bit), stamp (32), sequence (3), source index (3), event kind (2), severity (2), incident number (12), wall clock (32), bay (6), bay group (3), uplink (2), segment (3), power domain (3), intake temperature (8), exhaust temperature (8), drive temperature (8), fan speed (12), rail status (4). Event kind codes are 0 = link drop, 1 = retrain, 2 = throttle, 3 = failover, and they are copied from the source.
- R3: A record's stamp is the counter value in the cycle its strobe was sampled. The counter never restarts outside reset. Across accepted records, the pair {stamp, sequence} strictly increases.
- R4: When several strobes share a cycle, lower source indices are written first. Sequence numbers run 0, 1, 2, … in that order, and each record carries its source index together with that source's kind, severity and location.
- R5: The telemetry fields hold the telemetry inputs of the strobe cycle, not of any later cycle.
- R6: The wall-clock field holds the `wall_time` input of the strobe cycle and has no effect on ordering.
- R7: The incident number starts at 0 and increments by one for each cycle `new_incident` is high; otherwise it does not change. An event strobed in the same cycle as the pulse carries the new number.
- R8: With an empty FIFO and an idle output, a record strobed at clock edge k is shown at the output after edge k+2. A shown record keeps `rec_valid` high and `rec_data` unchanged until it is accepted with `rec_ready`.
- R9: An event whose write turn arrives while the FIFO holds `FIFO_DEPTH` records is dropped and adds one to `drop_count`. The counter saturates at all ones and never decreases.
- R10: Strobes sampled while the previous batch still has more than one record left to write are dropped, and each of them adds one to `drop_count`.
- R11: The first record written after any drop has its overflow flag set to 1. Every other record has the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_stb | input | N_SRC | One-cycle event strobe per source |
| src_kind | input | 2*N_SRC | Event kind per source, source i in bits [2i+1:2i] |
| src_sev | input | 2*N_SRC | Severity per source |
| src_loc | input | 17*N_SRC | Location per source: bay, group, uplink, segment, power domain (MSB first) |
| wall_time | input | 32 | Untrusted wall-clock value |
| tel_intake | input | 8 | Intake air temperature |
| tel_exhaust | input | 8 | Exhaust air temperature |
| tel_drive | input | 8 | Drive temperature |
| tel_fan | input | 12 | Fan speed |
| tel_rail | input | 4 | Rail status bits |
| new_incident | input | 1 | Advances the incident number |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Consumer accepts the shown record |
| rec_data | output | 144 | Record, layout per R2 |
| drop_count | output | DROP_W | Saturating count of lost events |

## Verification
A strobe sampled at edge k reaches the batch register at that edge, the FIFO memory at edge k+1 and the output register at edge k+2. The drop counter and the overflow mark change at the edge that follows the cycle in which the loss happened. The bench drives every input at the falling edge and applies the same per-edge timing in its own cycle model, then compares outputs at the next falling edge. Each output is therefore checked exactly one edge after the inputs that produced it. Ordering is also checked apart from the model, by comparing every accepted record with the one accepted before it.

// File: rtl/evtrec_pkg.sv
package evtrec_pkg;
  localparam int TS_W   = 32;
  localparam int WALL_W = 32;
  localparam int CID_W  = 12;
  localparam int SRC_W  = 3;
  localparam int BAY_W  = 6;
  localparam int GRP_W  = 3;
  localparam int UPL_W  = 2;
  localparam int SEG_W  = 3;
  localparam int PDOM_W = 3;
  localparam int TEMP_W = 8;
  localparam int FAN_W  = 12;
  localparam int RAIL_W = 4;

  typedef enum logic [1:0] {
    EV_DROP     = 2'd0,
    EV_RETRAIN  = 2'd1,
    EV_THROTTLE = 2'd2,
    EV_FAILOVER = 2'd3
  } evt_kind_e;

  typedef struct packed {
    logic [BAY_W-1:0]  bay;
    logic [GRP_W-1:0]  grp;
    logic [UPL_W-1:0]  upl;
    logic [SEG_W-1:0]  seg;
    logic [PDOM_W-1:0] pdom;
  } loc_t;

  typedef struct packed {
    logic [TEMP_W-1:0] intake;
    logic [TEMP_W-1:0] exhaust;
    logic [TEMP_W-1:0] drive;
    logic [FAN_W-1:0]  fan;
    logic [RAIL_W-1:0] rail;
  } snap_t;

  typedef struct packed {
    logic              ovf;
    logic [TS_W-1:0]   ts;
    logic [SRC_W-1:0]  seq;
    logic [SRC_W-1:0]  src;
    logic [1:0]        kind;
    logic [1:0]        sev;
    logic [CID_W-1:0]  cid;
    logic [WALL_W-1:0] wall;
    loc_t              loc;
    snap_t             snap;
  } rec_t;

  localparam int LOC_W = $bits(loc_t);
  localparam int REC_W = $bits(rec_t);
endpackage

// File: rtl/evtrec_capture.sv
module evtrec_capture
  import evtrec_pkg::*;
#(
  parameter int N_SRC = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_SRC-1:0]              stb,
  input  logic [N_SRC-1:0][1:0]         kind,
  input  logic [N_SRC-1:0][1:0]         sev,
  input  loc_t [N_SRC-1:0]              loc,
  input  logic [WALL_W-1:0]             wall,
  input  snap_t                         snap,
  input  logic                          incident,
  input  logic [N_SRC-1:0]              grant,
  output logic [N_SRC-1:0]              pend_q,
  output logic [N_SRC-1:0]              orig_q,
  output logic [N_SRC-1:0][1:0]         b_kind,
  output logic [N_SRC-1:0][1:0]         b_sev,
  output loc_t [N_SRC-1:0]              b_loc,
  output logic [TS_W-1:0]               b_ts,
  output logic [WALL_W-1:0]             b_wall,
  output logic [CID_W-1:0]              b_cid,
  output snap_t                         b_snap,
  output logic [SRC_W:0]                busy_cnt,
  output logic [TS_W-1:0]               ts_q,
  output logic [CID_W-1:0]              cid_q
);
  logic [N_SRC-1:0] remain;
  logic             load;
  logic [CID_W-1:0] cid_nxt;

  assign remain  = pend_q & ~grant;
  assign load    = (remain == '0) && (stb != '0);
  assign cid_nxt = cid_q + CID_W'(incident);

  always_comb begin
    busy_cnt = '0;
    if (remain != '0) begin
      for (int i = 0; i < N_SRC; i++) begin
        busy_cnt = busy_cnt + (SRC_W+1)'(stb[i]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q   <= '0;
      cid_q  <= '0;
      pend_q <= '0;
      orig_q <= '0;
    end else begin
      ts_q  <= ts_q + 1'b1;
      cid_q <= cid_nxt;
      if (load) begin
        pend_q <= stb;
        orig_q <= stb;
      end else begin
        pend_q <= remain;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      b_ts   <= ts_q;
      b_wall <= wall;
      b_cid  <= cid_nxt;
      b_snap <= snap;
    end
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (load && stb[g]) begin
        b_kind[g] <= kind[g];
        b_sev[g]  <= sev[g];
        b_loc[g]  <= loc[g];
      end
    end
  end
endmodule

// File: rtl/evtrec_serial.sv
module evtrec_serial
  import evtrec_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int DROP_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_SRC-1:0]      pend,
  input  logic [N_SRC-1:0]      orig,
  input  logic [N_SRC-1:0][1:0] b_kind,
  input  logic [N_SRC-1:0][1:0] b_sev,
  input  loc_t [N_SRC-1:0]      b_loc,
  input  logic [TS_W-1:0]       b_ts,
  input  logic [WALL_W-1:0]     b_wall,
  input  logic [CID_W-1:0]      b_cid,
  input  snap_t                 b_snap,
  input  logic [SRC_W:0]        busy_cnt,
  input  logic                  fifo_full,
  output logic [N_SRC-1:0]      grant,
  output logic                  wr_en,
  output rec_t                  wr_rec,
  output logic [DROP_W-1:0]     drop_q
);
  logic              found;
  logic [SRC_W-1:0]  idx;
  logic [SRC_W-1:0]  seq;
  logic              full_drop;
  logic [SRC_W:0]    drops_now;
  logic [DROP_W:0]   drop_sum;
  logic              ovf_q;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend[i] && !found) begin
        found    = 1'b1;
        idx      = SRC_W'(i);
        grant[i] = 1'b1;
      end
    end
    seq = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (orig[i] && (SRC_W'(i) < idx)) begin
        seq = seq + 1'b1;
      end
    end
  end

  assign wr_en     = found && !fifo_full;
  assign full_drop = found && fifo_full;
  assign drops_now = busy_cnt + (SRC_W+1)'(full_drop);
  assign drop_sum  = {1'b0, drop_q} + (DROP_W+1)'(drops_now);

  always_comb begin
    wr_rec      = '0;
    wr_rec.ovf  = ovf_q;
    wr_rec.ts   = b_ts;
    wr_rec.seq  = seq;
    wr_rec.src  = idx;
    wr_rec.kind = b_kind[idx];
    wr_rec.sev  = b_sev[idx];
    wr_rec.cid  = b_cid;
    wr_rec.wall = b_wall;
    wr_rec.loc  = b_loc[idx];
    wr_rec.snap = b_snap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      drop_q <= drop_sum[DROP_W] ? '1 : drop_sum[DROP_W-1:0];
      ovf_q  <= (ovf_q && !wr_en) || (drops_now != '0);
    end
  end
endmodule

// File: rtl/evtrec_fifo.sv
module evtrec_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  output logic          full,
  output logic [LW-1:0] level,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          rd_en;
  logic          wr_ok;

  assign full  = (level == LW'(DEPTH));
  assign wr_ok = wr_en && !full;
  assign rd_en = (level != '0) && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      mem[wp] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      out_data <= mem[rp];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp        <= '0;
      rp        <= '0;
      level     <= '0;
      out_valid <= 1'b0;
    end else begin
      if (wr_ok) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      level <= level + LW'(wr_ok) - LW'(rd_en);
      if (rd_en)          out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/evtrec_builder.sv
module evtrec_builder
  import evtrec_pkg::*;
#(
  parameter int N_SRC      = 4,
  parameter int FIFO_DEPTH = 16,
  parameter int DROP_W     = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [N_SRC-1:0]        src_stb,
  input  logic [2*N_SRC-1:0]      src_kind,
  input  logic [2*N_SRC-1:0]      src_sev,
  input  logic [LOC_W*N_SRC-1:0]  src_loc,
  input  logic [WALL_W-1:0]       wall_time,
  input  logic [TEMP_W-1:0]       tel_intake,
  input  logic [TEMP_W-1:0]       tel_exhaust,
  input  logic [TEMP_W-1:0]       tel_drive,
  input  logic [FAN_W-1:0]        tel_fan,
  input  logic [RAIL_W-1:0]       tel_rail,
  input  logic                    new_incident,
  output logic                    rec_valid,
  input  logic                    rec_ready,
  output logic [REC_W-1:0]        rec_data,
  output logic [DROP_W-1:0]       drop_count
);
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

  logic [N_SRC-1:0][1:0] kind_a, sev_a, b_kind, b_sev;
  loc_t [N_SRC-1:0]      loc_a, b_loc;
  snap_t                 snap_in, b_snap;
  logic [N_SRC-1:0]      pend, orig, grant;
  logic [TS_W-1:0]       b_ts, ts_now;
  logic [WALL_W-1:0]     b_wall;
  logic [CID_W-1:0]      b_cid, cid_now;
  logic [SRC_W:0]        busy_cnt;
  logic                  fifo_full, wr_en;
  logic [LVL_W-1:0]      fifo_lvl;
  rec_t                  wr_rec;

  assign kind_a  = src_kind;
  assign sev_a   = src_sev;
  assign loc_a   = src_loc;
  assign snap_in = '{intake: tel_intake, exhaust: tel_exhaust, drive: tel_drive,
                     fan: tel_fan, rail: tel_rail};

  evtrec_capture #(.N_SRC(N_SRC)) i_capture (
    .clk(clk), .rst(rst), .stb(src_stb), .kind(kind_a), .sev(sev_a), .loc(loc_a),
    .wall(wall_time), .snap(snap_in), .incident(new_incident), .grant(grant),
    .pend_q(pend), .orig_q(orig), .b_kind(b_kind), .b_sev(b_sev), .b_loc(b_loc),
    .b_ts(b_ts), .b_wall(b_wall), .b_cid(b_cid), .b_snap(b_snap),
    .busy_cnt(busy_cnt), .ts_q(ts_now), .cid_q(cid_now)
  );

  evtrec_serial #(.N_SRC(N_SRC), .DROP_W(DROP_W)) i_serial (
    .clk(clk), .rst(rst), .pend(pend), .orig(orig), .b_kind(b_kind), .b_sev(b_sev),
    .b_loc(b_loc), .b_ts(b_ts), .b_wall(b_wall), .b_cid(b_cid), .b_snap(b_snap),
    .busy_cnt(busy_cnt), .fifo_full(fifo_full), .grant(grant), .wr_en(wr_en),
    .wr_rec(wr_rec), .drop_q(drop_count)
  );

  evtrec_fifo #(.DEPTH(FIFO_DEPTH), .W(REC_W)) i_fifo (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_rec), .full(fifo_full),
    .level(fifo_lvl), .out_valid(rec_valid), .out_ready(rec_ready), .out_data(rec_data)
  );
endmodule

// File: rtl/evtrec_checker.sv
module evtrec_checker
  import evtrec_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DROP_W     = 16,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              rec_valid,
  input logic              rec_ready,
  input logic [REC_W-1:0]  rec_data,
  input logic [DROP_W-1:0] drop_count,
  input logic              new_incident,
  input logic [TS_W-1:0]   cur_ts,
  input logic [CID_W-1:0]  cur_cid,
  input logic [LVL_W-1:0]  fifo_level
);
  rec_t                    r;
  logic                    have_last;
  logic [TS_W+SRC_W-1:0]   last_key, key;

  assign r   = rec_t'(rec_data);
  assign key = {r.ts, r.seq};

  always_ff @(posedge clk) begin
    if (rst) begin
      have_last <= 1'b0;
      last_key  <= '0;
    end else if (rec_valid && rec_ready) begin
      have_last <= 1'b1;
      last_key  <= key;
    end
  end

  p_ts_step_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cur_ts == $past(cur_ts) + 1'b1);

  p_order_r3: assert property (@(posedge clk) disable iff (rst)
    rec_valid && rec_ready && have_last |-> key > last_key);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_data));

  p_drop_mono_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drop_count >= $past(drop_count));

  p_level_r9: assert property (@(posedge clk) disable iff (rst)
    fifo_level <= LVL_W'(FIFO_DEPTH));

  p_cid_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !new_incident |=> $stable(cur_cid));

  p_cid_step_r7: assert property (@(posedge clk) disable iff (rst)
    new_incident |=> cur_cid == CID_W'($past(cur_cid) + 1'b1));
endmodule

bind evtrec_builder evtrec_checker #(.FIFO_DEPTH(FIFO_DEPTH), .DROP_W(DROP_W)) i_chk (
  .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_ready(rec_ready),
  .rec_data(rec_data), .drop_count(drop_count), .new_incident(new_incident),
  .cur_ts(ts_now), .cur_cid(cid_now), .fifo_level(fifo_lvl)
);

// File: tb/test_evtrec_builder.sv
`timescale 1ns/1ps
module test_evtrec_builder;
  import evtrec_pkg::*;

  localparam int N     = 4;
  localparam int DEPTH = 16;
  localparam int DW    = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]       src_stb = '0;
  logic [2*N-1:0]     src_kind = '0, src_sev = '0;
  logic [LOC_W*N-1:0] src_loc = '0;
  logic [WALL_W-1:0]  wall_time = '0;
  logic [TEMP_W-1:0]  tel_intake = '0, tel_exhaust = '0, tel_drive = '0;
  logic [FAN_W-1:0]   tel_fan = '0;
  logic [RAIL_W-1:0]  tel_rail = '0;
  logic               new_incident = 1'b0;
  logic               rec_ready = 1'b0;
  logic               rec_valid;
  logic [REC_W-1:0]   rec_data;
  logic [DW-1:0]      drop_count;

  always #2.5 clk = ~clk;

  evtrec_builder #(.N_SRC(N), .FIFO_DEPTH(DEPTH), .DROP_W(DW)) i_evtrec_builder (
    .clk(clk), .rst(rst), .src_stb(src_stb), .src_kind(src_kind), .src_sev(src_sev),
    .src_loc(src_loc), .wall_time(wall_time), .tel_intake(tel_intake),
    .tel_exhaust(tel_exhaust), .tel_drive(tel_drive), .tel_fan(tel_fan),
    .tel_rail(tel_rail), .new_incident(new_incident), .rec_valid(rec_valid),
    .rec_ready(rec_ready), .rec_data(rec_data), .drop_count(drop_count)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // cycle model built from the requirements
  logic [N-1:0]         m_bmask, m_borig;
  logic [N-1:0][1:0]    m_bkind, m_bsev;
  loc_t [N-1:0]         m_bloc;
  logic [TS_W-1:0]      m_bts, m_ts;
  logic [WALL_W-1:0]    m_bwall;
  logic [CID_W-1:0]     m_bcid, m_cid;
  snap_t                m_bsnap;
  rec_t                 m_q[$];
  rec_t                 m_out;
  bit                   m_oval, m_ovfp;
  int                   m_drop;
  bit                   b_have;
  logic [TS_W+SRC_W-1:0] b_last;

  task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ones(input logic [N-1:0] v);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic model_update();
    int idx, seq, busy, drops;
    bit wr, fdrop, rd, load;
    logic [N-1:0] remain;
    logic [N-1:0][1:0] ka, sa;
    loc_t [N-1:0] la;
    rec_t nr;
    if (rst) begin
      m_bmask = '0; m_borig = '0; m_ts = '0; m_cid = '0; m_q.delete();
      m_oval = 0; m_ovfp = 0; m_drop = 0; b_have = 0;
      return;
    end
    ka = src_kind; sa = src_sev; la = src_loc;
    idx = -1;
    for (int i = N-1; i >= 0; i--) if (m_bmask[i]) idx = i;
    wr = (idx >= 0) && (m_q.size() < DEPTH);
    fdrop = (idx >= 0) && !wr;
    rd = (m_q.size() > 0) && (!m_oval || rec_ready);
    nr = '0;
    if (idx >= 0) begin
      seq = 0;
      for (int i = 0; i < idx; i++) seq += int'(m_borig[i]);
      nr.ovf = m_ovfp; nr.ts = m_bts; nr.seq = SRC_W'(seq); nr.src = SRC_W'(idx);
      nr.kind = m_bkind[idx]; nr.sev = m_bsev[idx]; nr.cid = m_bcid; nr.wall = m_bwall;
      nr.loc = m_bloc[idx]; nr.snap = m_bsnap;
    end
    remain = m_bmask & ~((idx >= 0) ? (N'(1) << idx) : '0);
    busy = (remain != '0) ? ones(src_stb) : 0;
    load = (remain == '0) && (src_stb != '0);
    drops = busy + int'(fdrop);
    if (rd) begin m_out = m_q.pop_front(); m_oval = 1; end
    else if (rec_ready) m_oval = 0;
    if (wr) m_q.push_back(nr);
    m_ovfp = (m_ovfp && !wr) || (drops > 0);
    m_drop = (m_drop + drops > 65535) ? 65535 : m_drop + drops;
    if (new_incident) m_cid = m_cid + 1'b1;
    if (load) begin
      m_bmask = src_stb; m_borig = src_stb; m_bts = m_ts; m_bcid = m_cid;
      m_bwall = wall_time;
      m_bsnap = '{intake: tel_intake, exhaust: tel_exhaust, drive: tel_drive,
                  fan: tel_fan, rail: tel_rail};
      for (int i = 0; i < N; i++) if (src_stb[i]) begin
        m_bkind[i] = ka[i]; m_bsev[i] = sa[i]; m_bloc[i] = la[i];
      end
    end else m_bmask = remain;
    m_ts = m_ts + 1'b1;
  endtask

  task automatic compare();
    rec_t a;
    chk("R8 rec_valid", 160'(rec_valid), 160'(m_oval));
    chk("R9 R10 drop_count", 160'(drop_count), 160'(m_drop));
    if (rec_valid && m_oval) begin
      a = rec_t'(rec_data);
      chk("R3 stamp", 160'(a.ts), 160'(m_out.ts));
      chk("R4 source and sequence", 160'({a.src, a.seq}), 160'({m_out.src, m_out.seq}));
      chk("R2 kind severity location", 160'({a.kind, a.sev, a.loc}),
          160'({m_out.kind, m_out.sev, m_out.loc}));
      chk("R5 telemetry snapshot", 160'(a.snap), 160'(m_out.snap));
      chk("R6 wall clock", 160'(a.wall), 160'(m_out.wall));
      chk("R7 incident number", 160'(a.cid), 160'(m_out.cid));
      chk("R11 overflow flag", 160'(a.ovf), 160'(m_out.ovf));
    end
  endtask

  task automatic step(input logic [N-1:0] stb, input logic rdy, input logic inc);
    rec_t a;
    src_stb = stb; rec_ready = rdy; new_incident = inc;
    src_kind = 8'($urandom); src_sev = 8'($urandom);
    src_loc = LOC_W*N'({$urandom, $urandom, $urandom});
    wall_time = $urandom;
    tel_intake = 8'($urandom); tel_exhaust = 8'($urandom); tel_drive = 8'($urandom);
    tel_fan = 12'($urandom); tel_rail = 4'($urandom);
    if (!rst && rec_valid && rec_ready) begin
      a = rec_t'(rec_data);
      if (b_have) chk("R3 order increases", 160'({a.ts, a.seq} > b_last), 160'(1));
      b_have = 1; b_last = {a.ts, a.seq};
    end
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    rst = 1'b1;
    repeat (4) step('0, 1'b0, 1'b0);
    rst = 1'b0;
    step('0, 1'b1, 1'b0);
    chk("R1 reset valid", 160'(rec_valid), 160'(0));
    chk("R1 reset drops", 160'(drop_count), 160'(0));
    // single event: shown after two edges
    step(4'b0100, 1'b1, 1'b0);
    step('0, 1'b1, 1'b0);
    chk("R8 not yet shown", 160'(rec_valid), 160'(0));
    step('0, 1'b1, 1'b0);
    chk("R8 shown after two edges", 160'(rec_valid), 160'(1));
    repeat (3) step('0, 1'b1, 1'b0);
    // all sources at once with an incident pulse
    step(4'b1111, 1'b1, 1'b1);
    repeat (8) step('0, 1'b1, 1'b0);
    // back-to-back batches: busy drops
    step(4'b1011, 1'b1, 1'b0);
    step(4'b0110, 1'b1, 1'b0);
    repeat (8) step('0, 1'b1, 1'b0);
    // fill while stalled: full drops and overflow flag
    repeat (24) step(4'b0001, 1'b0, 1'b0);
    chk("R9 drops counted", 160'(drop_count != 0), 160'(1));
    repeat (5) step('0, 1'b0, 1'b0);
    repeat (30) step('0, 1'b1, 1'b0);
    step(4'b1000, 1'b1, 1'b0);
    repeat (4) step('0, 1'b1, 1'b0);
    // random traffic
    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] s;
      for (int i = 0; i < N; i++) s[i] = ($urandom % 8) == 0;
      step(s, ($urandom % 4) != 0, ($urandom % 32) == 0);
    end
    repeat (40) step('0, 1'b1, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule